// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of signed 8-bit activation vectors by an N x N signed 8-bit weight matrix. It uses a square grid of multiply-accumulate cells. Each cell keeps one weight in place. Activations travel rightward one cell per cycle, and partial sums travel downward one cell per cycle. Neighbouring cells are the only ones that exchange operands or sums, and no cell reads a memory while a job runs.

A job has two phases. The first is a load phase: while the block is idle, N weight rows are shifted in from the top edge, one row per strobe. The second is a streaming phase, which a start pulse opens and which carries a row count M. Once it is open, M activation vectors are accepted on the left edge, and idle gaps between them are allowed. Inside the block, row i of each vector is delayed by i cycles. Output column j is delayed by N-1-j cycles, so every column of a product row leaves the bottom edge in the same cycle. A done pulse marks the cycle in which the last product row is presented.

Top module: `wsSystolicMm`

## Requirements
- R1: While idle, each cycle with `wValid` high shifts `wRow` into the top row of weights and moves every stored row down by one. After N strobes, the row given first sits in the bottom row. Weight column j is taken from `wRow[j*8 +: 8]`.
- R2: For an accepted activation vector a, where element i is `actRow[i*8 +: 8]`, result column j equals the signed sum over i of a[i]*W[i][j]. It is given as a signed 32-bit value in `result[j*32 +: 32]`.
- R3: A vector accepted at a clock edge is presented on `result` after the edge 2N-2 edges later, that is 2N-1 cycles after the cycle in which it was driven. Results come out in acceptance order.
- R4: All bits of `resValid` are either all high or all low in every cycle. Every column of a product row is presented in the same cycle.
- R5: `done` is high for exactly one cycle, and that is the cycle in which the last of the M product rows is presented. After that the block is idle again.
- R6: `wValid` has no effect while a job is running, so the stored weights are unchanged.
- R7: `actValid` is ignored while idle and after M vectors of the current job have been accepted. No `resValid` follows from it.
- R8: `start` is ignored while a job is running, and it is also ignored when `numRows` is zero.
- R9: After reset, `resValid`, `result` and `done` are all zero.
- R10: Idle cycles between accepted vectors are allowed. Each vector keeps the latency of R3, and `done` follows the last vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a streaming job when idle |
| numRows | input | RW (8) | Number of vectors M in the job, sampled with `start` |
| wValid | input | 1 | Weight row strobe, honoured only when idle |
| wRow | input | N*8 | One weight row, column j in bits j*8 upward |
| actValid | input | 1 | Activation vector strobe |
| actRow | input | N*8 | One activation vector, element i in bits i*8 upward |
| result | output | N*32 | One product row, column j in bits j*32 upward |
| resValid | output | N | Per-column valid flags for `result` |
| done | output | 1 | High in the cycle the last product row of a job is presented |

## Verification
The hardest situation to reach is an irregular stream. In it, accepted vectors have gaps between them, extra strobes arrive after the row count is used up, a second start shows up mid-job, and weight strobes arrive during streaming. All of these happen while earlier rows are still in the skewed pipeline. The bench drives a random job with random gaps and with `wValid` held high on junk data the whole time. It pulses `start` halfway through and keeps `actValid` high after the last counted vector. It then checks that only M correct rows appear, each 2N-1 cycles after its own acceptance, and that `done` lands on the last one. A follow-up job reuses the weights without reloading them, which shows that they were not disturbed.

// File: rtl/wsmmPkg.sv
package wsmmPkg;
  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  typedef struct packed {
    logic loadEn;
    logic feedEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/wsmmDelay.sv
module wsmmDelay #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [D];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < D; k++) stage[k] <= '0;
    end else begin
      stage[0] <= d;
      for (int k = 1; k < D; k++) stage[k] <= stage[k-1];
    end
  end

  assign q = stage[D-1];
endmodule

// File: rtl/wsmmCell.sv
module wsmmCell #(
  parameter int AW = 8,
  parameter int PW = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic signed [AW-1:0] wgt,
  input  logic signed [AW-1:0] act,
  input  logic signed [PW-1:0] psIn,
  output logic signed [PW-1:0] psOut
);
  localparam int MW = 2 * AW;

  logic signed [MW-1:0] prod;
  logic signed [PW-1:0] prodExt;

  assign prod    = act * wgt;
  assign prodExt = {{(PW-MW){prod[MW-1]}}, prod};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) psOut <= '0;
    else       psOut <= psIn + prodExt;
  end
endmodule

// File: rtl/wsmmArray.sv
module wsmmArray
  import wsmmPkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 8,
  parameter int PW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strb,
  input  logic [N*AW-1:0] wRow,
  input  logic [N*AW-1:0] actRow,
  output logic [N*PW-1:0] result,
  output logic [N-1:0]    resValid
);
  logic signed [AW-1:0] wReg [N][N];
  logic signed [AW-1:0] actH [N][N];
  logic signed [PW-1:0] psV  [N+1][N];
  logic [N-1:0]         colValid;

  genvar i, j;
  generate
    for (j = 0; j < N; j++) begin : g_top
      assign psV[0][j] = '0;
    end

    for (i = 0; i < N; i++) begin : g_row
      if (i == 0) begin : g_noSkew
        assign actH[0][0] = actRow[AW-1:0];
      end else begin : g_skew
        wsmmDelay #(.W(AW), .D(i)) u_skew (
          .clk(clk), .rstN(rstN),
          .d(actRow[i*AW +: AW]), .q(actH[i][0]));
      end

      for (j = 0; j < N; j++) begin : g_col
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)            wReg[i][j] <= '0;
          else if (strb.loadEn) wReg[i][j] <= (i == 0) ? wRow[j*AW +: AW] : wReg[(i == 0) ? 0 : i-1][j];
        end

        if (j > 0) begin : g_actPipe
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) actH[i][j] <= '0;
            else       actH[i][j] <= actH[i][j-1];
          end
        end

        wsmmCell #(.AW(AW), .PW(PW)) u_cell (
          .clk(clk), .rstN(rstN),
          .wgt(wReg[i][j]), .act(actH[i][j]),
          .psIn(psV[i][j]), .psOut(psV[i+1][j]));
      end
    end

    for (j = 0; j < N; j++) begin : g_out
      wsmmDelay #(.W(1), .D(N + j)) u_valid (
        .clk(clk), .rstN(rstN), .d(strb.feedEn), .q(colValid[j]));

      if (j == N - 1) begin : g_noDeskew
        assign result[j*PW +: PW] = psV[N][j];
        assign resValid[j]        = colValid[j];
      end else begin : g_deskew
        wsmmDelay #(.W(PW + 1), .D(N - 1 - j)) u_deskew (
          .clk(clk), .rstN(rstN),
          .d({colValid[j], psV[N][j]}),
          .q({resValid[j], result[j*PW +: PW]}));
      end
    end
  endgenerate
endmodule

// File: rtl/wsmmCtrl.sv
module wsmmCtrl
  import wsmmPkg::*;
#(
  parameter int N  = 4,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [RW-1:0] numRows,
  input  logic          wValid,
  input  logic          actValid,
  output ctrlStrobes_t  strb,
  output logic          busy,
  output logic          done
);
  localparam int SW = $clog2(2 * N);
  localparam logic [SW-1:0] LAST_GAP = SW'(2 * N - 2);

  ctrlState_t    state;
  logic [RW-1:0] rowsLeft;
  logic [SW-1:0] sinceLast;

  always_comb begin
    strb.loadEn = (state == ST_IDLE) && wValid;
    strb.feedEn = (state == ST_RUN) && actValid && (rowsLeft != '0);
    busy        = (state == ST_RUN);
    done        = (state == ST_RUN) && (rowsLeft == '0) && (sinceLast == LAST_GAP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rowsLeft  <= '0;
      sinceLast <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start && (numRows != '0)) begin
            state     <= ST_RUN;
            rowsLeft  <= numRows;
            sinceLast <= '0;
          end
        end
        ST_RUN: begin
          if (strb.feedEn) begin
            rowsLeft  <= rowsLeft - 1'b1;
            sinceLast <= '0;
          end else if (sinceLast != LAST_GAP) begin
            sinceLast <= sinceLast + 1'b1;
          end
          if (done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wsSystolicMm.sv
module wsSystolicMm
  import wsmmPkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 8,
  parameter int PW = 32,
  parameter int RW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [RW-1:0]   numRows,
  input  logic            wValid,
  input  logic [N*AW-1:0] wRow,
  input  logic            actValid,
  input  logic [N*AW-1:0] actRow,
  output logic [N*PW-1:0] result,
  output logic [N-1:0]    resValid,
  output logic            done
);
  ctrlStrobes_t strb;
  logic         busy;

  wsmmCtrl #(.N(N), .RW(RW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .numRows(numRows),
    .wValid(wValid), .actValid(actValid),
    .strb(strb), .busy(busy), .done(done));

  wsmmArray #(.N(N), .AW(AW), .PW(PW)) u_array (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wRow(wRow), .actRow(actRow),
    .result(result), .resValid(resValid));
endmodule

// File: rtl/wsmmCheck.sv
module wsmmCheck #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic         done,
  input logic         busy,
  input logic [N-1:0] resValid
);
  a_r4_cols_aligned: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(resValid) == 0) || ($countones(resValid) == N));

  a_r5_done_with_rows: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (&resValid));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_valid_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    (|resValid) |-> busy);
endmodule

bind wsSystolicMm wsmmCheck #(.N(N)) u_check (
  .clk(clk), .rstN(rstN), .done(done), .busy(busy), .resValid(resValid));

// File: tb/wsSystolicMm_bench.sv
module wsSystolicMm_bench;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int PW = 32;
  localparam int RW = 8;
  localparam int TA = 6;

  localparam logic signed [7:0] TAB_W [N][N] = '{
    '{ 8'sd3,    -8'sd2,   8'sd127, -8'sd128 },
    '{ -8'sd5,   8'sd1,    8'sd0,   -8'sd128 },
    '{ 8'sd7,    8'sd100,  -8'sd9,  -8'sd128 },
    '{ 8'sd0,    -8'sd60,  8'sd11,  -8'sd128 }
  };
  localparam logic signed [7:0] TAB_A [TA][N] = '{
    '{ 8'sd1,    8'sd0,    8'sd0,    8'sd0    },
    '{ 8'sd0,    8'sd0,    8'sd0,    8'sd1    },
    '{ -8'sd128, -8'sd128, -8'sd128, -8'sd128 },
    '{ 8'sd127,  8'sd127,  8'sd127,  8'sd127  },
    '{ 8'sd12,   -8'sd34,  8'sd56,   -8'sd78  },
    '{ 8'sd0,    8'sd0,    8'sd0,    8'sd0    }
  };

  logic            clk = 1'b0;
  logic            rstN;
  logic            start;
  logic [RW-1:0]   numRows;
  logic            wValid;
  logic [N*AW-1:0] wRow;
  logic            actValid;
  logic [N*AW-1:0] actRow;
  logic [N*PW-1:0] result;
  logic [N-1:0]    resValid;
  logic            done;

  int checks = 0, errors = 0, cyc = 0;
  int expM = 0, outIdx = 0, doneSeen = 0;
  int expC [64][N];
  int feedCyc [64];
  logic signed [7:0] curW [N][N];
  logic signed [7:0] curA [64][N];

  always #4 clk = ~clk;

  wsSystolicMm #(.N(N), .AW(AW), .PW(PW), .RW(RW)) u_wsSystolicMm (
    .clk(clk), .rstN(rstN), .start(start), .numRows(numRows),
    .wValid(wValid), .wRow(wRow), .actValid(actValid), .actRow(actRow),
    .result(result), .resValid(resValid), .done(done));

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic void computeExp(input int m);
    for (int r = 0; r < m; r++)
      for (int j = 0; j < N; j++) begin
        int s = 0;
        for (int i = 0; i < N; i++) s += int'(curA[r][i]) * int'(curW[i][j]);
        expC[r][j] = s;
      end
  endfunction

  function automatic logic [N*AW-1:0] packA(input int r);
    logic [N*AW-1:0] v;
    for (int i = 0; i < N; i++) v[i*AW +: AW] = curA[r][i];
    return v;
  endfunction

  // Monitor: values sampled at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (|resValid) begin
        if (outIdx >= expM) begin
          chk(1'b0, "R7 unexpected result row", outIdx, expM);
        end else begin
          chk(resValid == {N{1'b1}}, "R4 columns together", int'(resValid), (1 << N) - 1);
          for (int j = 0; j < N; j++)
            chk($signed(result[j*PW +: PW]) == expC[outIdx][j], "R2 product value",
                $signed(result[j*PW +: PW]), expC[outIdx][j]);
          chk(cyc - feedCyc[outIdx] == 2*N - 1, "R3 latency", cyc - feedCyc[outIdx], 2*N - 1);
          if (outIdx == expM - 1) chk(done, "R5 done on last row", int'(done), 1);
        end
        outIdx++;
      end
      if (done) begin
        chk((|resValid) && (outIdx == expM), "R5 done position", outIdx, expM);
        doneSeen++;
      end
    end
  end

  task automatic loadWeights();
    for (int r = N - 1; r >= 0; r--) begin
      @(negedge clk);
      wValid = 1'b1;
      for (int j = 0; j < N; j++) wRow[j*AW +: AW] = curW[r][j];
    end
    @(negedge clk);
    wValid = 1'b0;
    wRow   = '0;
  endtask

  // Runs one job of m rows; gaps adds random idle cycles (R10); noisy adds R6/R7/R8 stimulus.
  task automatic runJob(input int m, input bit gaps, input bit noisy);
    int target;
    target = doneSeen + 1;
    computeExp(m);
    outIdx = 0;
    expM   = m;
    @(negedge clk);
    start   = 1'b1;
    numRows = RW'(m);
    for (int r = 0; r < m; r++) begin
      if (gaps) begin
        int g = $urandom_range(0, 2);
        for (int k = 0; k < g; k++) begin
          @(negedge clk);
          start = 1'b0; actValid = 1'b0;
          if (noisy) begin wValid = 1'b1; wRow = N*AW'($urandom); end
        end
      end
      @(negedge clk);
      start    = (noisy && r == m / 2);  // R8: start while busy
      numRows  = noisy ? RW'(3) : RW'(m);
      actValid = 1'b1;
      actRow   = packA(r);
      feedCyc[r] = cyc;
      if (noisy) begin wValid = 1'b1; wRow = N*AW'($urandom); end  // R6
    end
    @(negedge clk);
    start = 1'b0;
    if (noisy) begin
      actRow = '1;  // R7: extra strobes past the row count
      repeat (3) @(negedge clk);
    end
    actValid = 1'b0;
    wait (doneSeen == target);
    @(negedge clk);
    wValid = 1'b0;
    wRow   = '0;
    repeat (2*N + 2) @(negedge clk);
    chk(outIdx == m, "R7 row count", outIdx, m);
    chk(doneSeen == target, "R5 single done", doneSeen, target);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; numRows = '0; wValid = 1'b0; wRow = '0;
    actValid = 1'b0; actRow = '0;
    repeat (3) @(negedge clk);
    chk(resValid == '0, "R9 resValid after reset", int'(resValid), 0);
    chk(done == 1'b0, "R9 done after reset", int'(done), 0);
    chk(result == '0, "R9 result after reset", int'(result[PW-1:0]), 0);
    rstN = 1'b1;

    // Table job: fixed weights, consecutive vectors (R1, R2, R3, R4, R5)
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) curW[i][j] = TAB_W[i][j];
    for (int r = 0; r < TA; r++) for (int i = 0; i < N; i++) curA[r][i] = TAB_A[r][i];
    loadWeights();
    runJob(TA, 1'b0, 1'b0);

    // Random job with gaps and noise (R10, R6, R7, R8)
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) curW[i][j] = 8'($urandom);
    for (int r = 0; r < 12; r++) for (int i = 0; i < N; i++) curA[r][i] = 8'($urandom);
    loadWeights();
    runJob(12, 1'b1, 1'b1);

    // Reuse weights without reloading: shows R6 weights survived
    for (int r = 0; r < 5; r++) for (int i = 0; i < N; i++) curA[r][i] = 8'($urandom);
    runJob(5, 1'b0, 1'b0);

    // R8: start with zero rows, then R7: strobes while idle
    @(negedge clk);
    start = 1'b1; numRows = '0;
    @(negedge clk);
    start = 1'b0; actValid = 1'b1; actRow = '1;
    repeat (3) @(negedge clk);
    actValid = 1'b0;
    repeat (2*N + 2) @(negedge clk);
    chk(outIdx == expM, "R8 zero-row start ignored", outIdx, expM);
    chk(doneSeen == 3, "R8 no done after zero-row start", doneSeen, 3);

    // Single-row job (R5 done on the only row)
    curA[0][0] = -8'sd128; curA[0][1] = 8'sd127; curA[0][2] = -8'sd1; curA[0][3] = 8'sd64;
    runJob(1, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual %0d expected 0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule